// File: doc/BRIEF.md
# Configuration Readback Serializer

This block sends the contents of a frame-organized configuration store out through one serial data line. The store is an internal array of `NUM_FRAMES` words of `FRAME_BITS` bits. The stored word of each frame is computed from its index. A rising edge on the trigger input starts a readback. The serial line then carries a short idle preamble, followed by every frame in turn. Each frame is a zero start bit followed by its data bits, most significant bit first. A busy flag stays high while the engine is working.

Two static options change the content of the stream. In capture mode, a group of live signals is sampled at the trigger edge, and the inverted samples replace a few stored bits of one frame. In RAM mode, a live RAM image replaces a few stored bits of another frame. A third static option makes a falling trigger edge abort the readback. After an abort, the engine flushes for one frame time and then accepts a new trigger. A static select picks the readback clock: either the default configuration clock or a user clock. All state advances on rising edges of the selected clock.

Each frame word is loaded into a holding register during a six-cycle window. The window ends with that frame's start bit. At the start bit, the word moves into the output shifter, and the shifter then shifts one bit per clock.

Top module: `cfg_readback_ser`

## Requirements
- R1: While reset is asserted and after it is released, with no trigger, `dout` is 1 and `rip` is 0.
- R2: A rising `trig` edge sampled while idle makes `rip` go high from the next cycle. `rip` stays high through the last data bit of the last frame, then drops in the following cycle, and `dout` returns to 1.
- R3: After the trigger edge, `dout` is 1 for 5 cycles. Then `NUM_FRAMES` frames follow back to back, each one a start bit of 0 followed by `FRAME_BITS` data bits, MSB first. The stored word of frame f is the low `FRAME_BITS` bits of f*0x9E3779B1 + 0x6D2B79F5.
- R4: With `cap_mode`=1, the low `NUM_CAP` bits of frame `CAP_FRAME` carry the bitwise inverse of `cap_sig` as sampled at the trigger edge. Later changes of `cap_sig` have no effect on the stream.
- R5: With `cap_mode`=0, those capture bit positions carry the stored word bits.
- R6: With `ram_mode`=1, the low `RAM_W` bits of frame `RAM_FRAME` carry `ram_bits` uninverted. With `ram_mode`=0, they carry the stored bits.
- R7: A frame's word is taken during the six cycles that end with its start bit. A change of `ram_bits` made during the start-bit cycle of `RAM_FRAME` does not alter that frame.
- R8: With `abort_mode`=1, a falling `trig` edge during a readback sends `dout` high. `rip` stays high for exactly `FRAME_BITS`+1 cycles and then drops. A rising `trig` edge during that flush is ignored. A later rising edge starts a full readback.
- R9: With `abort_mode`=0, a falling `trig` edge during a readback has no effect, and the readback completes.
- R10: When a readback ends with `trig` still high, no new readback starts until `trig` falls and rises again.
- R11: With `clk_sel`=1, the engine advances only on `user_clk`, and `cfg_clk` edges have no effect. With `user_clk` stopped, a raised trigger leaves `rip` at 0 and `dout` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Default readback clock |
| user_clk | input | 1 | Alternative user-supplied readback clock |
| clk_sel | input | 1 | Static clock option: 0 selects cfg_clk, 1 selects user_clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_mode | input | 1 | Static option: insert inverted captured signals |
| abort_mode | input | 1 | Static option: falling trigger aborts a readback |
| ram_mode | input | 1 | Static option: insert live RAM image bits |
| trig | input | 1 | Readback trigger, rising edge starts |
| cap_sig | input | NUM_CAP | Live signals sampled at the trigger edge |
| ram_bits | input | RAM_W | Live RAM image bits |
| dout | output | 1 | Serial readback data, idles high |
| rip | output | 1 | Readback in progress |

## Verification
Every result is counted in readback-clock cycles from the edge that samples the trigger. The preamble occupies cycles 1 to 5, and the start bit of frame f falls in cycle 6+f*(FRAME_BITS+1), with its data bits in the cycles after it. `rip` falls one cycle after the last data bit. After an aborting edge, the flush covers the next `FRAME_BITS`+1 cycles. The bench drives and samples on the falling clock edge and counts cycles from the edge that sees the stimulus, so each sample lands in the middle of the cycle that the requirement names.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

  typedef enum logic [2:0] {
    RB_IDLE  = 3'd0,
    RB_PRE   = 3'd1,
    RB_START = 3'd2,
    RB_DATA  = 3'd3,
    RB_FLUSH = 3'd4
  } rb_state_e;

  // length of the load window, ending with (and counting) a start bit
  localparam int unsigned LOAD_WIN = 6;

  // stored configuration content of frame f, before truncation
  function automatic logic [31:0] cfg_seed(input int unsigned f);
    logic [31:0] fv;
    fv = f;
    return fv * 32'h9E37_79B1 + 32'h6D2B_79F5;
  endfunction

endpackage

// File: rtl/rbk_trig_edge.sv
module rbk_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rise,
  output logic fall
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig;
  end

  assign rise = trig & ~trig_q;
  assign fall = ~trig & trig_q;

endmodule

// File: rtl/rbk_seq.sv
module rbk_seq #(
  parameter int unsigned FRAME_BITS = 8,
  parameter int unsigned NUM_FRAMES = 4,
  localparam int unsigned CW = $clog2(FRAME_BITS + 1),
  localparam int unsigned FW = $clog2(NUM_FRAMES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_rise,
  input  logic          trig_fall,
  input  logic          abort_mode,
  output logic          rip,
  output logic          start_bit,
  output logic          data_phase,
  output logic          load_win,
  output logic [FW-1:0] load_idx,
  output logic          cap_take
);
  import rbk_pkg::*;

  localparam int unsigned PRE_LEN  = LOAD_WIN - 1;
  localparam int unsigned WIN_FROM = FRAME_BITS - (LOAD_WIN - 1);

  rb_state_e     st;
  logic [CW-1:0] cnt;
  logic [FW-1:0] frm;
  logic          busy;
  logic          abort_hit;
  logic          last_bit;
  logic          last_frame;

  initial if (FRAME_BITS < LOAD_WIN) $error("FRAME_BITS must be at least the load window");

  assign busy       = (st == RB_PRE) || (st == RB_START) || (st == RB_DATA);
  assign abort_hit  = abort_mode && trig_fall && busy;
  assign last_bit   = (cnt == CW'(FRAME_BITS - 1));
  assign last_frame = (frm == FW'(NUM_FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= RB_IDLE;
      cnt <= '0;
      frm <= '0;
    end else if (abort_hit) begin
      st  <= RB_FLUSH;
      cnt <= '0;
    end else begin
      case (st)
        RB_IDLE: if (trig_rise) begin
          st  <= RB_PRE;
          cnt <= '0;
          frm <= '0;
        end
        RB_PRE: begin
          if (cnt == CW'(PRE_LEN - 1)) begin
            st  <= RB_START;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        RB_START: begin
          st  <= RB_DATA;
          cnt <= '0;
        end
        RB_DATA: begin
          if (last_bit) begin
            cnt <= '0;
            if (last_frame) st <= RB_IDLE;
            else begin
              st  <= RB_START;
              frm <= frm + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        RB_FLUSH: begin
          if (cnt == CW'(FRAME_BITS)) begin
            st  <= RB_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= RB_IDLE;
      endcase
    end
  end

  assign rip        = (st != RB_IDLE);
  assign start_bit  = (st == RB_START);
  assign data_phase = (st == RB_DATA);
  assign cap_take   = (st == RB_IDLE) && trig_rise;
  assign load_win   = (st == RB_PRE) || (st == RB_START) ||
                      ((st == RB_DATA) && (cnt >= CW'(WIN_FROM)) && !last_frame);
  assign load_idx   = (st == RB_DATA) ? frm + 1'b1 : frm;

  AST_RIP_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rip) |-> $past(trig_rise)); // R2
  AST_ABORT_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_mode && trig_fall && busy) |=> (rip && !load_win && !data_phase)); // R8
  AST_NO_ABORT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!abort_mode && data_phase && !last_bit) |=> data_phase); // R9
  AST_NO_RETRIG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RB_FLUSH) |-> !cap_take); // R8

endmodule

// File: rtl/rbk_frame_src.sv
module rbk_frame_src #(
  parameter int unsigned FRAME_BITS = 8,
  parameter int unsigned NUM_FRAMES = 4,
  parameter int unsigned NUM_CAP    = 3,
  parameter int unsigned CAP_FRAME  = 1,
  parameter int unsigned RAM_W      = 2,
  parameter int unsigned RAM_FRAME  = 2,
  localparam int unsigned FW = $clog2(NUM_FRAMES + 1),
  localparam int unsigned AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_take,
  input  logic [NUM_CAP-1:0]    cap_sig,
  input  logic                  cap_mode,
  input  logic                  ram_mode,
  input  logic [RAM_W-1:0]      ram_bits,
  input  logic [FW-1:0]         load_idx,
  output logic [FRAME_BITS-1:0] word
);
  logic [FRAME_BITS-1:0] cfg_mem [NUM_FRAMES];
  logic [NUM_CAP-1:0]    cap_q;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_store
    assign cfg_mem[g] = FRAME_BITS'(rbk_pkg::cfg_seed(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_q <= '0;
    else if (cap_take) cap_q <= cap_sig;
  end

  always_comb begin
    word = cfg_mem[load_idx[AW-1:0]];
    if (cap_mode && (load_idx == FW'(CAP_FRAME))) word[NUM_CAP-1:0] = ~cap_q;
    if (ram_mode && (load_idx == FW'(RAM_FRAME))) word[RAM_W-1:0]   = ram_bits;
  end

  AST_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_take |=> $stable(cap_q)); // R4

endmodule

// File: rtl/rbk_shifter.sv
module rbk_shifter #(
  parameter int unsigned FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_win,
  input  logic                  start_bit,
  input  logic                  data_phase,
  input  logic [FRAME_BITS-1:0] word,
  output logic                  dout
);
  logic [FRAME_BITS-1:0] hold_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [2:0]            win_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
    end else begin
      if (load_win)        hold_q <= word;
      if (start_bit)       sh_q   <= hold_q;
      else if (data_phase) sh_q   <= {sh_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  assign dout = start_bit ? 1'b0 : (data_phase ? sh_q[FRAME_BITS-1] : 1'b1);

  // run length of the load window, for the checks below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         win_run <= '0;
    else if (!load_win)                 win_run <= '0;
    else if (win_run != 3'd7)           win_run <= win_run + 1'b1;
  end

  AST_WIN_AT_MOST_SIX: assert property (@(posedge clk) disable iff (!rst_n)
    load_win |-> (win_run < 3'd6)); // R7
  AST_START_ENDS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    start_bit |-> (load_win && win_run == 3'd5)); // R7

endmodule

// File: rtl/cfg_readback_ser.sv
module cfg_readback_ser #(
  parameter int unsigned FRAME_BITS = 8,
  parameter int unsigned NUM_FRAMES = 4,
  parameter int unsigned NUM_CAP    = 3,
  parameter int unsigned CAP_FRAME  = 1,
  parameter int unsigned RAM_W      = 2,
  parameter int unsigned RAM_FRAME  = 2
) (
  input  logic               cfg_clk,
  input  logic               user_clk,
  input  logic               clk_sel,
  input  logic               rst_n,
  input  logic               cap_mode,
  input  logic               abort_mode,
  input  logic               ram_mode,
  input  logic               trig,
  input  logic [NUM_CAP-1:0] cap_sig,
  input  logic [RAM_W-1:0]   ram_bits,
  output logic               dout,
  output logic               rip
);
  localparam int unsigned FW = $clog2(NUM_FRAMES + 1);

  logic                  rb_clk;
  logic                  trig_rise;
  logic                  trig_fall;
  logic                  start_bit;
  logic                  data_phase;
  logic                  load_win;
  logic [FW-1:0]         load_idx;
  logic                  cap_take;
  logic [FRAME_BITS-1:0] word;

  // static option: readback clock source
  assign rb_clk = clk_sel ? user_clk : cfg_clk;

  rbk_trig_edge u_edge (
    .clk   (rb_clk),
    .rst_n (rst_n),
    .trig  (trig),
    .rise  (trig_rise),
    .fall  (trig_fall)
  );

  rbk_seq #(.FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES)) u_seq (
    .clk        (rb_clk),
    .rst_n      (rst_n),
    .trig_rise  (trig_rise),
    .trig_fall  (trig_fall),
    .abort_mode (abort_mode),
    .rip        (rip),
    .start_bit  (start_bit),
    .data_phase (data_phase),
    .load_win   (load_win),
    .load_idx   (load_idx),
    .cap_take   (cap_take)
  );

  rbk_frame_src #(
    .FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES), .NUM_CAP(NUM_CAP),
    .CAP_FRAME(CAP_FRAME), .RAM_W(RAM_W), .RAM_FRAME(RAM_FRAME)
  ) u_src (
    .clk      (rb_clk),
    .rst_n    (rst_n),
    .cap_take (cap_take),
    .cap_sig  (cap_sig),
    .cap_mode (cap_mode),
    .ram_mode (ram_mode),
    .ram_bits (ram_bits),
    .load_idx (load_idx),
    .word     (word)
  );

  rbk_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk        (rb_clk),
    .rst_n      (rst_n),
    .load_win   (load_win),
    .start_bit  (start_bit),
    .data_phase (data_phase),
    .word       (word),
    .dout       (dout)
  );

  AST_IDLE_LINE_HIGH: assert property (@(posedge rb_clk) disable iff (!rst_n)
    !rip |-> dout); // R1
  AST_ZERO_ONLY_IN_FRAME: assert property (@(posedge rb_clk) disable iff (!rst_n)
    !dout |-> (rip && (start_bit || data_phase))); // R3

endmodule

// File: tb/cfg_readback_ser_test.sv
module cfg_readback_ser_test;
  localparam int FB = 8;
  localparam int NF = 4;
  localparam int NC = 3;
  localparam int CF = 1;
  localparam int RW = 2;
  localparam int RF = 2;

  logic clk = 1'b0;
  logic user_run = 1'b0;
  logic user_clk;
  logic clk_sel = 1'b0, rst_n = 1'b0;
  logic cap_mode = 1'b0, abort_mode = 1'b0, ram_mode = 1'b0, trig = 1'b0;
  logic [NC-1:0] cap_sig = '0;
  logic [RW-1:0] ram_bits = '0;
  logic dout, rip;
  int n_chk = 0, n_err = 0;

  always #10ns clk = ~clk;
  assign user_clk = clk & user_run;

  cfg_readback_ser #(.FRAME_BITS(FB), .NUM_FRAMES(NF), .NUM_CAP(NC),
    .CAP_FRAME(CF), .RAM_W(RW), .RAM_FRAME(RF)) uut (
    .cfg_clk(clk), .user_clk(user_clk), .clk_sel(clk_sel), .rst_n(rst_n),
    .cap_mode(cap_mode), .abort_mode(abort_mode), .ram_mode(ram_mode),
    .trig(trig), .cap_sig(cap_sig), .ram_bits(ram_bits), .dout(dout), .rip(rip));

  // expected frame content, restated from the requirements
  function automatic logic [FB-1:0] exp_word(input int f, input bit cm,
      input logic [NC-1:0] cv, input bit rm, input logic [RW-1:0] rv);
    logic [31:0] s;
    logic [FB-1:0] w;
    s = 32'h6D2B_79F5;
    for (int i = 0; i < f; i++) s = s + 32'h9E37_79B1;
    w = s[FB-1:0];
    if (cm && f == CF) for (int i = 0; i < NC; i++) w[i] = !cv[i];
    if (rm && f == RF) for (int i = 0; i < RW; i++) w[i] = rv[i];
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // trigger edge is the next rising clock edge after this task is entered
  task automatic take_readback(input bit cm, input logic [NC-1:0] cv, input bit rm,
      input logic [RW-1:0] rv, input int drop_at, input bit flip_cap,
      input bit flip_ram, input string tag);
    logic [FB-1:0] got, exp;
    bit pre_ok, rip_ok;
    int k;
    string ft;
    k = 0; pre_ok = 1; rip_ok = 1; got = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); k++;
      if (dout !== 1'b1 || rip !== 1'b1) pre_ok = 0;
      if (k == 1 && flip_cap) cap_sig = ~cap_sig;
      if (k == drop_at) trig = 1'b0;
    end
    chk(pre_ok, {tag, " R3 preamble"}, pre_ok, 1);
    for (int f = 0; f < NF; f++) begin
      @(negedge clk); k++;
      chk(dout === 1'b0 && rip === 1'b1, {tag, " R3 start bit"}, dout, 0);
      if (flip_ram && f == RF) ram_bits = ~ram_bits;
      if (k == drop_at) trig = 1'b0;
      for (int b = 0; b < FB; b++) begin
        @(negedge clk); k++;
        got = {got[FB-2:0], dout};
        if (rip !== 1'b1) rip_ok = 0;
        if (k == drop_at) trig = 1'b0;
      end
      exp = exp_word(f, cm, cv, rm, rv);
      if (f == CF) ft = cm ? " R4 capture frame" : " R5 capture frame";
      else if (f == RF) ft = flip_ram ? " R7 ram frame" : " R6 ram frame";
      else ft = " R3 frame";
      chk(got === exp, {tag, ft}, got, exp);
    end
    chk(rip_ok, {tag, " R2 rip during data"}, rip_ok, 1);
    @(negedge clk);
    chk(rip === 1'b0 && dout === 1'b1, {tag, " R2 end"}, {rip, dout}, 1);
  endtask

  initial begin
    #(20ns * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(dout === 1'b1 && rip === 1'b0, "R1 in reset", {rip, dout}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(dout === 1'b1 && rip === 1'b0, "R1 after reset", {rip, dout}, 1);

    // capture on, live signals change after the edge; trigger held high after
    cap_mode = 1; cap_sig = 3'b101; trig = 1;
    take_readback(1, 3'b101, 0, '0, 0, 1, 0, "dir1");
    ok = 1;
    repeat (8) begin @(negedge clk); if (rip !== 1'b0 || dout !== 1'b1) ok = 0; end
    chk(ok, "R10 no restart while held", ok, 1);
    trig = 0; repeat (2) @(negedge clk);

    // capture off, RAM on, RAM image flips during its frame's start bit
    cap_mode = 0; ram_mode = 1; ram_bits = 2'b10; cap_sig = 3'b011; trig = 1;
    take_readback(0, 3'b011, 1, 2'b10, 0, 0, 1, "dir2");
    trig = 0; repeat (2) @(negedge clk);

    // falling trigger with abort disabled
    abort_mode = 0; ram_mode = 0; trig = 1;
    take_readback(0, cap_sig, 0, '0, 12, 0, 0, "R9 fall ignored");
    repeat (2) @(negedge clk);

    // abort
    abort_mode = 1; trig = 1;
    repeat (10) @(negedge clk);
    trig = 0;
    ok = 1;
    for (int i = 1; i <= FB + 1; i++) begin
      @(negedge clk);
      if (rip !== 1'b1 || dout !== 1'b1) ok = 0;
      if (i == 3) trig = 1;
    end
    chk(ok, "R8 flush length", ok, 1);
    @(negedge clk);
    chk(rip === 1'b0, "R8 flush ends", rip, 0);
    ok = 1;
    repeat (4) begin @(negedge clk); if (rip !== 1'b0) ok = 0; end
    chk(ok, "R8 retrigger in flush ignored", ok, 1);
    trig = 0; repeat (2) @(negedge clk);
    cap_mode = 1; cap_sig = 3'b110; trig = 1;
    take_readback(1, 3'b110, 0, '0, 0, 0, 0, "R8 rearm");
    trig = 0; abort_mode = 0; repeat (2) @(negedge clk);

    // random content
    for (int it = 0; it < 6; it++) begin
      logic [NC-1:0] cv;
      logic [RW-1:0] rv;
      bit cm, rm;
      cm = $urandom() % 2; rm = $urandom() % 2;
      cv = NC'($urandom()); rv = RW'($urandom());
      cap_mode = cm; ram_mode = rm; cap_sig = cv; ram_bits = rv; trig = 1;
      take_readback(cm, cv, rm, rv, 0, 0, 0, "rand");
      trig = 0;
      repeat (1 + $urandom() % 3) @(negedge clk);
    end

    // user clock select
    cap_mode = 0; ram_mode = 0;
    repeat (3) @(negedge clk);
    clk_sel = 1; trig = 1;
    ok = 1;
    repeat (10) begin @(negedge clk); if (rip !== 1'b0 || dout !== 1'b1) ok = 0; end
    chk(ok, "R11 stopped user clock", ok, 1);
    user_run = 1;
    take_readback(0, cap_sig, 0, '0, 0, 0, 0, "R11 user clock");
    trig = 0;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule